// File: doc/BRIEF.md
# Three-Stage Instruction Pipeline Flow Controller

This block is the front end and flow control of a fetch, decode and execute pipeline for a 32-bit fixed-length instruction set. It drives word-aligned fetch addresses to an instruction memory port. The memory returns its data in the same cycle. The block keeps a fetch slot, a decode slot and an execute slot, each with a valid bit and its instruction address. The execute slot is shown to the execute logic together with the program counter value that the executing instruction reads.

The execute logic reports taken branches, and any other write of the program counter, through a taken flag and a target address. A taken branch from a valid executing instruction kills the younger two slots and restarts fetch at the target. An interrupt request lets the executing instruction retire, kills the younger slots and sends fetch to a fixed vector in low memory. At the same time the block captures the address where execution must later resume. A stall from the instruction memory freezes the whole pipeline.

Top module: `pipe3_flow_ctrl`

## Requirements
- R1: Synchronous active-high reset clears all three valid bits and puts address 0 on the fetch port. The fetch slot becomes valid one cycle after reset is released, with the address held at 0. With no branch, interrupt or stall, the instruction at address 0 reaches execute (ex_valid=1) in the third cycle after release.
- R2: When not stalled and not redirected, a valid fetch slot moves the fetch address on by 4 each cycle. The two low bits of imem_addr are always 0.
- R3: While ex_valid is 1, ex_pc_view equals ex_addr + 8.
- R4: ex_instr is the word that imem_rdata returned while imem_addr held ex_addr.
- R5: br_taken with ex_valid=1 and no stall restarts fetch at br_target with its two low bits cleared. ex_valid is then 0 for two cycles, and the target instruction reaches execute in the third cycle.
- R6: br_taken has no effect while ex_valid is 0. The fetch sequence goes on unchanged.
- R7: irq with no stall asserts irq_ack in that cycle. The executing instruction still retires (ex_retire=1 if ex_valid). The next fetch address is the vector VEC_ADDR (default 0x18), and ex_valid is 0 for the next two cycles.
- R8: On irq_ack, irq_ret_addr is loaded at the next clock edge. The value is the decode slot's address if that slot is valid, and otherwise the fetch slot's address.
- R9: When irq_ack and an effective taken branch fall in the same cycle, irq_ret_addr takes the aligned branch target, and fetch goes to VEC_ADDR.
- R10: While imem_stall is 1, imem_addr, ex_valid, ex_addr, ex_instr and irq_ret_addr keep their values, ex_retire and irq_ack are 0, and br_taken and irq have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_stall | input | 1 | Instruction memory not ready; freezes all stages |
| imem_rdata | input | 32 | Instruction word for imem_addr, same cycle |
| br_taken | input | 1 | Executing instruction writes the program counter |
| br_target | input | 32 | New program counter value |
| irq | input | 1 | Interrupt request (level) |
| imem_addr | output | 32 | Word-aligned fetch address |
| ex_valid | output | 1 | Execute slot holds a live instruction |
| ex_addr | output | 32 | Address of the executing instruction |
| ex_instr | output | 32 | Executing instruction word |
| ex_pc_view | output | 32 | Program counter as read by the executing instruction |
| ex_retire | output | 1 | Executing instruction completes this cycle |
| irq_ack | output | 1 | Interrupt accepted this cycle |
| irq_ret_addr | output | 32 | Resume address captured at the last accepted interrupt |

## Verification
The assertions assume that imem_rdata is valid in the same cycle as imem_addr. They also assume that br_taken and irq are only meaningful in cycles without stall, and that reset is held for at least one edge before anything else is observed. The bench drives every input at the falling edge, with no glitches. It sweeps branch and interrupt arrival over each phase of pipeline refill, including right after reset and right after another redirect. It also raises br_taken and irq during stalls to show that they are ignored there.

// File: rtl/pipe3_pkg.sv
package pipe3_pkg;
  parameter int unsigned PC_W       = 32;
  parameter int unsigned INSTR_W    = 32;
  parameter int unsigned WORD_BYTES = 4;
  parameter int unsigned VIEW_AHEAD = 2;
  localparam int unsigned ALIGN_BITS = $clog2(WORD_BYTES);

  typedef logic [PC_W-1:0]    pc_t;
  typedef logic [INSTR_W-1:0] instr_t;

  typedef struct packed {
    logic   vld;
    pc_t    addr;
    instr_t instr;
  } slot_t;

  // force word alignment
  function automatic pc_t pc_align(input pc_t a);
    pc_t r;
    r = a;
    r[ALIGN_BITS-1:0] = '0;
    return r;
  endfunction

  // address of the following instruction
  function automatic pc_t pc_step(input pc_t a);
    return pc_align(a) + pc_t'(WORD_BYTES);
  endfunction

  // program counter as read by an executing instruction
  function automatic pc_t pc_view(input pc_t a);
    return a + pc_t'(WORD_BYTES * VIEW_AHEAD);
  endfunction
endpackage

// File: rtl/pipe3_fetch_pc.sv
module pipe3_fetch_pc
  import pipe3_pkg::*;
#(
  parameter pc_t RESET_ADDR = '0,
  parameter pc_t VEC_ADDR   = pc_t'(32'h18)
) (
  input  logic clk,
  input  logic rst,
  input  logic advance,
  input  logic br_fire,
  input  pc_t  br_target,
  input  logic irq_ack,
  output pc_t  fetch_addr,
  output logic fetch_valid
);
  pc_t  pc_q;
  logic vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= pc_align(RESET_ADDR);
      vld_q <= 1'b0;
    end else if (advance) begin
      if (irq_ack) begin
        pc_q  <= pc_align(VEC_ADDR);
        vld_q <= 1'b1;
      end else if (br_fire) begin
        pc_q  <= pc_align(br_target);
        vld_q <= 1'b1;
      end else if (!vld_q) begin
        vld_q <= 1'b1;
      end else begin
        pc_q <= pc_step(pc_q);
      end
    end
  end

  assign fetch_addr  = pc_align(pc_q);
  assign fetch_valid = vld_q;
endmodule

// File: rtl/pipe3_slot.sv
module pipe3_slot
  import pipe3_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  advance,
  input  logic  kill,
  input  slot_t slot_in,
  output slot_t slot_out
);
  slot_t q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q.vld <= 1'b0;
    end else if (advance) begin
      q.vld <= slot_in.vld & ~kill;
    end
  end

  always_ff @(posedge clk) begin
    if (advance) begin
      q.addr  <= slot_in.addr;
      q.instr <= slot_in.instr;
    end
  end

  assign slot_out = q;
endmodule

// File: rtl/pipe3_redirect.sv
module pipe3_redirect
  import pipe3_pkg::*;
(
  input  logic rst,
  input  logic stall,
  input  logic irq,
  input  logic ex_vld,
  input  logic br_taken,
  input  pc_t  br_target,
  input  logic dec_vld,
  input  pc_t  dec_addr,
  input  pc_t  fetch_addr,
  output logic advance,
  output logic br_fire,
  output logic irq_ack,
  output logic kill,
  output pc_t  ret_next
);
  always_comb begin
    advance = ~stall;
    br_fire = ~rst & ~stall & ex_vld & br_taken;
    irq_ack = ~rst & ~stall & irq;
    kill    = br_fire | irq_ack;
    if (br_fire)      ret_next = pc_align(br_target);
    else if (dec_vld) ret_next = dec_addr;
    else              ret_next = fetch_addr;
  end
endmodule

// File: rtl/pipe3_flow_ctrl.sv
module pipe3_flow_ctrl
  import pipe3_pkg::*;
#(
  parameter pc_t RESET_ADDR = '0,
  parameter pc_t VEC_ADDR   = pc_t'(32'h18)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               imem_stall,
  input  logic [INSTR_W-1:0] imem_rdata,
  input  logic               br_taken,
  input  logic [PC_W-1:0]    br_target,
  input  logic               irq,
  output logic [PC_W-1:0]    imem_addr,
  output logic               ex_valid,
  output logic [PC_W-1:0]    ex_addr,
  output logic [INSTR_W-1:0] ex_instr,
  output logic [PC_W-1:0]    ex_pc_view,
  output logic               ex_retire,
  output logic               irq_ack,
  output logic [PC_W-1:0]    irq_ret_addr
);
  localparam int unsigned NSTAGE = 3;

  // named internal events
  logic  advance, br_fire, kill, fetch_valid;
  pc_t   fetch_addr, ret_next, ret_q;
  slot_t chain [NSTAGE];

  pipe3_fetch_pc #(.RESET_ADDR(RESET_ADDR), .VEC_ADDR(VEC_ADDR)) u_fetch (
    .clk(clk), .rst(rst), .advance(advance), .br_fire(br_fire),
    .br_target(br_target), .irq_ack(irq_ack),
    .fetch_addr(fetch_addr), .fetch_valid(fetch_valid)
  );

  assign chain[0] = '{vld: fetch_valid, addr: fetch_addr, instr: imem_rdata};

  // decode then execute slot
  for (genvar g = 1; g < NSTAGE; g++) begin : g_slot
    pipe3_slot u_slot (
      .clk(clk), .rst(rst), .advance(advance), .kill(kill),
      .slot_in(chain[g-1]), .slot_out(chain[g])
    );
  end

  pipe3_redirect u_redir (
    .rst(rst), .stall(imem_stall), .irq(irq),
    .ex_vld(chain[2].vld), .br_taken(br_taken), .br_target(br_target),
    .dec_vld(chain[1].vld), .dec_addr(chain[1].addr), .fetch_addr(fetch_addr),
    .advance(advance), .br_fire(br_fire), .irq_ack(irq_ack), .kill(kill),
    .ret_next(ret_next)
  );

  always_ff @(posedge clk) begin
    if (rst)          ret_q <= '0;
    else if (irq_ack) ret_q <= ret_next;
  end

  assign imem_addr    = fetch_addr;
  assign ex_valid     = chain[2].vld;
  assign ex_addr      = chain[2].addr;
  assign ex_instr     = chain[2].instr;
  assign ex_pc_view   = pc_view(chain[2].addr);
  assign ex_retire    = chain[2].vld & advance;
  assign irq_ret_addr = ret_q;
endmodule

// File: rtl/pipe3_flow_chk.sv
module pipe3_flow_chk
  import pipe3_pkg::*;
#(
  parameter pc_t VEC_ADDR = pc_t'(32'h18)
) (
  input logic clk,
  input logic rst,
  input logic stall,
  input logic advance,
  input logic kill,
  input logic irq_ack,
  input logic fetch_valid,
  input logic dec_valid,
  input pc_t  dec_addr,
  input pc_t  imem_addr,
  input logic ex_valid,
  input pc_t  ex_pc_view,
  input pc_t  ret_addr
);
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (advance && !kill && fetch_valid) |=> imem_addr == $past(imem_addr) + 32'd4);

  a_r7_vector: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> imem_addr == pc_align(VEC_ADDR));

  a_r5_bubble: assert property (@(posedge clk) disable iff (rst)
    kill |=> !ex_valid ##1 !ex_valid);

  a_r10_freeze: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(imem_addr) && $stable(ex_valid) && $stable(ex_pc_view)
              && $stable(ret_addr));

  a_r3_view: assert property (@(posedge clk) disable iff (rst)
    (advance && dec_valid && !kill) |=> ex_valid && ex_pc_view == $past(dec_addr) + 32'd8);
endmodule

bind pipe3_flow_ctrl pipe3_flow_chk #(.VEC_ADDR(VEC_ADDR)) u_chk (
  .clk(clk), .rst(rst), .stall(imem_stall), .advance(advance), .kill(kill),
  .irq_ack(irq_ack), .fetch_valid(fetch_valid), .dec_valid(chain[1].vld),
  .dec_addr(chain[1].addr), .imem_addr(imem_addr), .ex_valid(ex_valid),
  .ex_pc_view(ex_pc_view), .ret_addr(irq_ret_addr)
);

// File: tb/pipe3_flow_ctrl_tb.sv
module pipe3_flow_ctrl_tb;
  localparam logic [31:0] VEC = 32'h18;

  logic clk = 1'b0;
  logic rst, imem_stall, br_taken, irq;
  logic [31:0] imem_rdata, br_target;
  logic [31:0] imem_addr, ex_addr, ex_instr, ex_pc_view, irq_ret_addr;
  logic ex_valid, ex_retire, irq_ack;

  int checks = 0;
  int errors = 0;

  // expected state, computed from the requirements
  logic m_fv, m_dv, m_ev;
  logic [31:0] m_pc, m_da, m_ea, m_ret;

  always #10 clk = ~clk;

  function automatic logic [31:0] word_of(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
  endfunction

  assign imem_rdata = word_of(imem_addr);

  pipe3_flow_ctrl u_dut (
    .clk(clk), .rst(rst), .imem_stall(imem_stall), .imem_rdata(imem_rdata),
    .br_taken(br_taken), .br_target(br_target), .irq(irq),
    .imem_addr(imem_addr), .ex_valid(ex_valid), .ex_addr(ex_addr),
    .ex_instr(ex_instr), .ex_pc_view(ex_pc_view), .ex_retire(ex_retire),
    .irq_ack(irq_ack), .irq_ret_addr(irq_ret_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_state(input string tag);
    chk({tag, " R2 fetch addr"}, imem_addr, m_pc);
    chk({tag, " R2 align"}, {30'd0, imem_addr[1:0]}, 32'd0);
    chk({tag, " ex_valid"}, {31'd0, ex_valid}, {31'd0, m_ev});
    chk({tag, " R8 ret addr"}, irq_ret_addr, m_ret);
    if (m_ev) begin
      chk({tag, " ex_addr"}, ex_addr, m_ea);
      chk({tag, " R3 pc view"}, ex_pc_view, m_ea + 32'd8);
      chk({tag, " R4 instr"}, ex_instr, word_of(m_ea));
    end
  endtask

  // one clock: drive at falling edge, predict, compare at next falling edge
  task automatic cyc(input string tag, input logic st, input logic ir,
                     input logic bt, input logic [31:0] tgt);
    logic fire, ack;
    imem_stall = st; irq = ir; br_taken = bt; br_target = tgt;
    #1;
    chk({tag, " retire"}, {31'd0, ex_retire}, {31'd0, m_ev & ~st});
    chk({tag, " irq_ack"}, {31'd0, irq_ack}, {31'd0, ir & ~st});
    if (!st) begin
      fire = m_ev & bt;
      ack  = ir;
      if (ack) m_ret = fire ? {tgt[31:2], 2'b00} : (m_dv ? m_da : m_pc);
      m_ev = m_dv & ~(fire | ack);
      m_ea = m_da;
      m_dv = m_fv & ~(fire | ack);
      m_da = m_pc;
      if (ack)       begin m_pc = VEC; m_fv = 1'b1; end
      else if (fire) begin m_pc = {tgt[31:2], 2'b00}; m_fv = 1'b1; end
      else if (!m_fv) m_fv = 1'b1;
      else m_pc = m_pc + 32'd4;
    end
    @(negedge clk);
    compare_state(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; imem_stall = 1'b0; irq = 1'b0; br_taken = 1'b0; br_target = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_fv = 0; m_dv = 0; m_ev = 0; m_pc = 0; m_da = 0; m_ea = 0; m_ret = 0;
    chk("R1 ex_valid after reset", {31'd0, ex_valid}, 32'd0);
    chk("R1 fetch addr after reset", imem_addr, 32'd0);
    chk("R1 ret addr after reset", irq_ret_addr, 32'd0);
  endtask

  task automatic run_plain(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag, 1'b0, 1'b0, 1'b0, 32'd0);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; imem_stall = 1'b0; irq = 1'b0; br_taken = 1'b0; br_target = '0;
    do_reset();
    // R1: first instruction reaches execute in the third cycle
    cyc("R1 c1", 0, 0, 0, 0);
    chk("R1 no exec c1", {31'd0, ex_valid}, 32'd0);
    cyc("R1 c2", 0, 0, 0, 0);
    chk("R1 no exec c2", {31'd0, ex_valid}, 32'd0);
    cyc("R1 c3", 0, 0, 0, 0);
    chk("R1 addr0 exec", {ex_addr[31:1], ex_valid}, 32'd1);
    run_plain("R2 R4 seq", 10);

    // R6: branch requests while execute is empty, each refill phase
    for (int k = 0; k < 3; k++) begin
      do_reset();
      run_plain("R6 pre", k);
      cyc("R6 ignored", 0, 0, 1, 32'h400);
      run_plain("R6 post", 4);
    end

    // R5: taken branches to several targets, aligned and not
    do_reset();
    run_plain("R5 fill", 4);
    for (int t = 0; t < 8; t++) begin
      cyc("R5 branch", 0, 0, 1, 32'h1000 + 32'(t * 36) + 32'(t % 4));
      chk("R5 bubble1", {31'd0, ex_valid}, 32'd0);
      cyc("R5 b2", 0, 0, 0, 0);
      chk("R5 bubble2", {31'd0, ex_valid}, 32'd0);
      cyc("R5 tgt", 0, 0, 0, 0);
      chk("R5 target exec", ex_addr, 32'h1000 + 32'(t * 36));
      run_plain("R5 run", t % 3);
    end

    // R7 R8: interrupts in each phase after reset and after a branch
    for (int k = 0; k < 6; k++) begin
      do_reset();
      run_plain("R8 pre", k);
      cyc("R7 irq", 0, 1, 0, 0);
      chk("R7 vector", imem_addr, VEC);
      run_plain("R7 post", 4);
      cyc("R8 br", 0, 0, 1, 32'h80);
      run_plain("R8 gap", k % 3);
      cyc("R8 irq after br", 0, 1, 0, 0);
      run_plain("R8 post", 3);
    end

    // R9: branch and interrupt in the same cycle
    do_reset();
    run_plain("R9 fill", 5);
    cyc("R9 both", 0, 1, 1, 32'h2222);
    chk("R9 ret is target", irq_ret_addr, 32'h2220);
    chk("R9 fetch vector", imem_addr, VEC);
    run_plain("R9 post", 4);

    // R10: stalls with branch and irq asserted, in several phases
    for (int k = 0; k < 5; k++) begin
      do_reset();
      run_plain("R10 pre", k);
      for (int s = 0; s < 3; s++) cyc("R10 stall", 1, s[0], 1, 32'h700);
      run_plain("R10 post", 4);
    end
    do_reset();
    run_plain("R10 fill", 4);
    for (int p = 0; p < 16; p++)
      cyc("R10 mix", p[1] & p[2], p == 9, p == 5, 32'h300);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule